// File: doc/BRIEF.md
# Multi-Segment Burst Read ROM Target

This block is a read-only memory target on an on-chip request/response bus. It holds one or more independent segments; each has its own base byte address and byte size, and its contents are fixed at build time by a computed fill pattern. A requester sends a single-flit read command carrying a byte address and a byte length. The block answers with a burst of response flits. The burst length follows from the requested length and the data-bus width, which is either 32 or 64 bits.

Both channels use valid/ready handshakes. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A response flit is consumed on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the flit on offer stays unchanged and no progress is made. The block handles one burst at a time. It keeps `cmd_ready` low from the cycle after it takes a command until the cycle after the last flit of that burst is consumed. The first flit of a burst appears in the cycle after the command is taken.

The block never changes its contents. A command that is malformed, falls outside every segment, or is not a read is answered with one error flit.

Top module: `burst_rom_target`

## Requirements
- R1: The data width parameter is 32 or 64. On a 64-bit bus, a full flit carries the word at the lower address in bits 31:0 and the following word in bits 63:32.
- R2: With 32-bit data, a valid read of `plen` bytes returns exactly plen/4 flits, each carrying one consecutive 32-bit word.
- R3: With 64-bit data and an even number of words (plen/4), a valid read returns exactly plen/8 flits, each carrying two words.
- R4: With 64-bit data and an odd word count, a valid read returns plen/8 + 1 flits. The last flit carries its one word in bits 31:0, and bits 63:32 are zero.
- R5: `rsp_reop` is high on the last flit of each response packet and low on every other flit.
- R6: `cmd_ready` is high whenever no burst is in progress. After a command is accepted, `rsp_valid` is high and `cmd_ready` is low in the next cycle. This state lasts until the last flit has been accepted. In the cycle after that, `rsp_valid` is low and `cmd_ready` is high.
- R7: A read is answered with one flit carrying `rsp_rerror`=1, `rsp_reop`=1 and zero data in any of these cases:
  - `plen` is 0 or not a multiple of 4;
  - the address is not a multiple of 4;
  - the range [addr, addr+plen) does not lie wholly inside one segment.
- R8: A command with `cmd_op` other than read (read is 2'b01; 2'b00, 2'b10 and 2'b11 are not reads), or with `cmd_eop`=0, is answered with a single error flit as in R7. Such a command never changes the contents that later reads return.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata`, `rsp_rerror` and `rsp_reop` stay stable. The read position advances only on an accepted flit.
- R10: A synchronous active-low reset abandons any burst in progress. In the cycle after a reset edge, `rsp_valid` is 0 and `cmd_ready` is 1.
- R11: The word at word offset i of segment s (segments numbered from 0) reads as {s+1 in bits 31:24, 8'h5A in bits 23:16, i in bits 15:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command flit offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_plen | input | PLEN_W | Requested length in bytes |
| cmd_op | input | 2 | Operation code; 2'b01 is read |
| cmd_eop | input | 1 | Command end-of-packet flag; must be 1 |
| rsp_valid | output | 1 | Response flit offered |
| rsp_ready | input | 1 | Requester takes the response flit |
| rsp_rdata | output | DATA_W | Response data |
| rsp_rerror | output | 1 | Error response flag |
| rsp_reop | output | 1 | Last flit of the response packet |

## Verification
The bench builds two instances, each with two segments: a 64-byte segment at 0x1000 and a 40-byte segment at 0x4000.

The main instance uses 64-bit data, so both even and odd word counts occur. Odd counts produce the half-filled final flit, including one where the following word exists in memory but must be masked. The range checks are exercised against a segment end, a segment start and the gap between segments. Random back-pressure and a reset in the middle of a burst cover stability and recovery.

A second instance with 32-bit data confirms that one word goes out per flit.

// File: rtl/burst_rom_pkg.sv
package burst_rom_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_READ   = 2'b01,
    OP_WRITE  = 2'b10,
    OP_LOCKED = 2'b11
  } rom_op_e;

  // Build-time fill pattern for segment seg, word idx.
  function automatic logic [31:0] preload_word(int unsigned seg, int unsigned idx,
                                               logic [7:0] key);
    return {8'(seg + 1), key, 16'(idx)};
  endfunction

endpackage

// File: rtl/rom_bank.sv
module rom_bank
  import burst_rom_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 30,
  parameter int DEPTH  = 16,
  parameter int SEG_ID = 0,
  parameter logic [7:0] FILL_KEY = 8'h5A
) (
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] flit
);
  localparam int WPF = DATA_W / 32;
  localparam int MW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = preload_word(SEG_ID, i, FILL_KEY);
  end

  // One read lane per word in a flit; words past the segment end read zero.
  for (genvar k = 0; k < WPF; k++) begin : g_lane
    logic [IDX_W:0] idx_k;
    assign idx_k = {1'b0, rd_idx} + (IDX_W+1)'(k);
    assign flit[32*k +: 32] = (idx_k < (IDX_W+1)'(DEPTH)) ? mem[idx_k[MW-1:0]] : 32'h0;
  end

endmodule

// File: rtl/rom_seg_decode.sv
module rom_seg_decode #(
  parameter int ADDR_W   = 32,
  parameter int PLEN_W   = 8,
  parameter int NUM_SEGS = 2,
  parameter int SEL_W    = 1,
  parameter logic [NUM_SEGS-1:0][ADDR_W-1:0] SEG_BASE = '0,
  parameter logic [NUM_SEGS-1:0][ADDR_W-1:0] SEG_SIZE = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PLEN_W-1:0]   plen,
  output logic [NUM_SEGS-1:0] hit_vec,
  output logic                hit_any,
  output logic [SEL_W-1:0]    sel,
  output logic [ADDR_W-1:0]   offset
);
  logic [ADDR_W:0]   span_end;
  logic [ADDR_W-1:0] off_arr [NUM_SEGS];

  assign span_end = {1'b0, addr} + (ADDR_W+1)'(plen);

  // Whole range must sit inside a segment; the extra bit keeps the end from wrapping.
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    localparam logic [ADDR_W:0] LO = {1'b0, SEG_BASE[g]};
    localparam logic [ADDR_W:0] HI = LO + {1'b0, SEG_SIZE[g]};
    assign hit_vec[g] = ({1'b0, addr} >= LO) && (span_end <= HI);
    assign off_arr[g] = addr - SEG_BASE[g];
  end

  always_comb begin
    hit_any = |hit_vec;
    sel     = '0;
    offset  = '0;
    for (int s = NUM_SEGS - 1; s >= 0; s--) begin
      if (hit_vec[s]) begin
        sel    = SEL_W'(s);
        offset = off_arr[s];
      end
    end
  end

endmodule

// File: rtl/rom_burst_seq.sv
module rom_burst_seq #(
  parameter int ADDR_W = 32,
  parameter int PLEN_W = 8,
  parameter int SEL_W  = 1,
  parameter int WPF    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_err,
  input  logic [SEL_W-1:0]  start_seg,
  input  logic [ADDR_W-3:0] start_widx,
  input  logic [PLEN_W-3:0] start_words,
  input  logic              rsp_ready,
  output logic              busy,
  output logic              err,
  output logic [SEL_W-1:0]  seg,
  output logic [ADDR_W-3:0] widx,
  output logic [PLEN_W-3:0] left,
  output logic              last
);
  assign last = err || (left <= (PLEN_W-2)'(WPF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      err  <= 1'b0;
      seg  <= '0;
      widx <= '0;
      left <= '0;
    end else if (start) begin
      busy <= 1'b1;
      err  <= start_err;
      seg  <= start_seg;
      widx <= start_widx;
      left <= start_words;
    end else if (busy && rsp_ready) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        widx <= widx + (ADDR_W-2)'(WPF);
        left <= left - (PLEN_W-2)'(WPF);
      end
    end
  end

  // R9: the read position moves only when a flit is taken
  p_no_advance_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_ready && !start |=> $stable(widx) && $stable(left) && busy);

  // R5: a non-final flit never ends the burst
  p_keep_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_ready && !last && !start |=> busy);

endmodule

// File: rtl/burst_rom_target.sv
module burst_rom_target
  import burst_rom_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 32,
  parameter int PLEN_W   = 8,
  parameter int NUM_SEGS = 2,
  parameter logic [NUM_SEGS-1:0][ADDR_W-1:0] SEG_BASE = {32'h0000_4000, 32'h0000_1000},
  parameter logic [NUM_SEGS-1:0][ADDR_W-1:0] SEG_SIZE = {32'd40, 32'd64},
  parameter logic [7:0] FILL_KEY = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PLEN_W-1:0] cmd_plen,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_eop,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rerror,
  output logic              rsp_reop
);
  localparam int WPF   = DATA_W / 32;
  localparam int SEL_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;
  localparam int WI_W  = ADDR_W - 2;
  localparam int NW_W  = PLEN_W - 2;

  if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
    $error("burst_rom_target: DATA_W must be 32 or 64");
  end

  logic [NUM_SEGS-1:0] hit_vec;
  logic                hit_any;
  logic [SEL_W-1:0]    dec_sel;
  logic [ADDR_W-1:0]   dec_off;
  rom_op_e             op;
  logic                cmd_fire, accept_ok;

  logic              cur_busy, cur_err, cur_last;
  logic [SEL_W-1:0]  cur_seg;
  logic [WI_W-1:0]   cur_widx;
  logic [NW_W-1:0]   cur_left;
  logic [DATA_W-1:0] bank_flit [NUM_SEGS];
  logic [DATA_W-1:0] sel_flit;

  rom_seg_decode #(
    .ADDR_W(ADDR_W), .PLEN_W(PLEN_W), .NUM_SEGS(NUM_SEGS), .SEL_W(SEL_W),
    .SEG_BASE(SEG_BASE), .SEG_SIZE(SEG_SIZE)
  ) u_decode (
    .addr(cmd_addr), .plen(cmd_plen), .hit_vec(hit_vec), .hit_any(hit_any),
    .sel(dec_sel), .offset(dec_off)
  );

  assign op        = rom_op_e'(cmd_op);
  assign cmd_ready = !cur_busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign accept_ok = hit_any && (op == OP_READ) && cmd_eop && (cmd_plen != '0)
                  && (cmd_plen[1:0] == 2'b00) && (dec_off[1:0] == 2'b00);

  rom_burst_seq #(
    .ADDR_W(ADDR_W), .PLEN_W(PLEN_W), .SEL_W(SEL_W), .WPF(WPF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_fire), .start_err(!accept_ok),
    .start_seg(dec_sel), .start_widx(dec_off[ADDR_W-1:2]),
    .start_words(cmd_plen[PLEN_W-1:2]), .rsp_ready(rsp_ready),
    .busy(cur_busy), .err(cur_err), .seg(cur_seg), .widx(cur_widx),
    .left(cur_left), .last(cur_last)
  );

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_bank
    rom_bank #(
      .DATA_W(DATA_W), .IDX_W(WI_W), .DEPTH(int'(SEG_SIZE[g] >> 2)),
      .SEG_ID(g), .FILL_KEY(FILL_KEY)
    ) u_bank (
      .rd_idx(cur_widx), .flit(bank_flit[g])
    );
  end

  assign sel_flit = bank_flit[cur_seg];

  if (WPF == 1) begin : g_narrow
    assign rsp_rdata = cur_err ? '0 : sel_flit;
  end else begin : g_wide
    // Odd tail: only the low word is meaningful, the high half is cleared.
    assign rsp_rdata = cur_err ? '0
                     : {(cur_left >= NW_W'(2)) ? sel_flit[DATA_W-1:32] : 32'h0, sel_flit[31:0]};
  end

  assign rsp_valid  = cur_busy;
  assign rsp_rerror = cur_busy && cur_err;
  assign rsp_reop   = cur_busy && cur_last;

  // R6: a taken command yields a response and closes the command channel
  p_cmd_opens_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid && !cmd_ready);

  // R6: consuming the final flit reopens the command channel
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_reop |=> !rsp_valid && cmd_ready);

  // R9: offered flit holds under back-pressure
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)
                                && $stable(rsp_reop) && $stable(rsp_rerror));

  // R7: error flits are single, terminal and empty
  p_err_flit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_rerror |-> rsp_reop && (rsp_rdata == '0));

  // R7: segments are decoded exclusively
  p_seg_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $onehot0(hit_vec));

  // R10: reset clears the burst
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid && cmd_ready);

endmodule

// File: tb/burst_rom_target_test.sv
module burst_rom_target_test;
  localparam logic [1:0][31:0] BASES = {32'h0000_4000, 32'h0000_1000};
  localparam logic [1:0][31:0] SIZES = {32'd40, 32'd64};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_eop, rsp_valid, rsp_ready, rsp_rerror, rsp_reop;
  logic [31:0] cmd_addr;
  logic [7:0]  cmd_plen;
  logic [1:0]  cmd_op;
  logic [63:0] rsp_rdata;

  logic        n_cmd_valid, n_cmd_ready, n_rsp_valid, n_rsp_rerror, n_rsp_reop;
  logic [31:0] n_cmd_addr, n_rsp_rdata;
  logic [7:0]  n_cmd_plen;

  burst_rom_target #(.DATA_W(64), .SEG_BASE(BASES), .SEG_SIZE(SIZES)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_plen(cmd_plen), .cmd_op(cmd_op), .cmd_eop(cmd_eop),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_rerror(rsp_rerror), .rsp_reop(rsp_reop));

  burst_rom_target #(.DATA_W(32), .SEG_BASE(BASES), .SEG_SIZE(SIZES)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .cmd_valid(n_cmd_valid), .cmd_ready(n_cmd_ready),
    .cmd_addr(n_cmd_addr), .cmd_plen(n_cmd_plen), .cmd_op(2'b01), .cmd_eop(1'b1),
    .rsp_valid(n_rsp_valid), .rsp_ready(1'b1), .rsp_rdata(n_rsp_rdata),
    .rsp_rerror(n_rsp_rerror), .rsp_reop(n_rsp_reop));

  int checks = 0, errors = 0;
  logic [63:0] q_data[$];
  bit          q_err[$], q_eop[$];
  string       q_tag[$];

  bit          want, last_acc, prev_stall;
  logic [31:0] w_addr;
  logic [7:0]  w_plen;
  logic [1:0]  w_op;
  bit          w_eop;
  string       w_note;
  int          rdy_mode;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int seg_of(logic [31:0] a, int unsigned len);
    for (int s = 0; s < 2; s++)
      if (longint'(a) >= longint'(BASES[s]) &&
          longint'(a) + len <= longint'(BASES[s]) + longint'(SIZES[s])) return s;
    return -1;
  endfunction

  function automatic logic [31:0] ref_word(int s, logic [31:0] a);
    logic [31:0] i = (a - BASES[s]) >> 2;
    return {8'(s + 1), 8'h5A, i[15:0]};
  endfunction

  task automatic push_cmd(logic [31:0] a, logic [7:0] plen, logic [1:0] op, bit eop, string note);
    int s = seg_of(a, plen);
    bit ok = (op == 2'b01) && eop && plen != 0 && plen % 4 == 0 && a % 4 == 0 && s >= 0;
    if (!ok) begin
      q_data.push_back(64'h0); q_err.push_back(1'b1); q_eop.push_back(1'b1);
      q_tag.push_back((op != 2'b01 || !eop) ? {"R8", note} : {"R7", note});
    end else begin
      int n = plen / 4;
      for (int k = 0; k < n; k += 2) begin
        logic [31:0] lo = ref_word(s, a + 32'(4 * k));
        logic [31:0] hi = (k + 1 < n) ? ref_word(s, a + 32'(4 * k + 4)) : 32'h0;
        bit e = (k + 2 >= n);
        q_data.push_back({hi, lo}); q_err.push_back(1'b0); q_eop.push_back(e);
        q_tag.push_back(((n % 2 == 1) && e) ? {"R4,R11", note} : {"R1,R3,R11", note});
      end
    end
  endtask

  task automatic step();
    bit empty;
    string t;
    @(negedge clk);
    cmd_valid = want; cmd_addr = w_addr; cmd_plen = w_plen; cmd_op = w_op; cmd_eop = w_eop;
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = ($urandom % 3) != 0;
      2: rsp_ready = ($urandom % 2) != 0;
      default: rsp_ready = 1'b0;
    endcase
    #1;
    empty = (q_data.size() == 0);
    chk(cmd_ready === empty, "R6", "cmd_ready", 64'(cmd_ready), 64'(empty));
    chk(rsp_valid === !empty, "R6", "rsp_valid", 64'(rsp_valid), 64'(!empty));
    if (!empty && rsp_valid === 1'b1) begin
      t = prev_stall ? {q_tag[0], ",R9"} : q_tag[0];
      chk(rsp_rdata === q_data[0], t, "rdata", rsp_rdata, q_data[0]);
      chk(rsp_rerror === q_err[0], t, "rerror", 64'(rsp_rerror), 64'(q_err[0]));
      chk(rsp_reop === q_eop[0], "R5", "reop", 64'(rsp_reop), 64'(q_eop[0]));
    end
    prev_stall = !empty && !rsp_ready;
    last_acc = want && empty;
    if (!empty && rsp_ready) begin
      void'(q_data.pop_front()); void'(q_err.pop_front());
      void'(q_eop.pop_front());  void'(q_tag.pop_front());
    end
    if (last_acc) push_cmd(w_addr, w_plen, w_op, w_eop, w_note);
  endtask

  task automatic issue(logic [31:0] a, logic [7:0] plen, logic [1:0] op, bit eop, string note);
    want = 1'b1; w_addr = a; w_plen = plen; w_op = op; w_eop = eop; w_note = note;
    do step(); while (!last_acc);
    want = 1'b0;
    while (q_data.size() != 0) step();
    step();
  endtask

  task automatic narrow_read(logic [31:0] a, logic [7:0] plen);
    int n = plen / 4;
    @(negedge clk);
    n_cmd_addr = a; n_cmd_plen = plen; n_cmd_valid = 1'b1;
    #1 chk(n_cmd_ready === 1'b1, "R6", "narrow cmd_ready", 64'(n_cmd_ready), 64'h1);
    @(negedge clk);
    n_cmd_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(n_rsp_valid === 1'b1, "R2", "narrow valid", 64'(n_rsp_valid), 64'h1);
      chk(n_rsp_rdata === ref_word(seg_of(a, plen), a + 32'(4 * k)), "R2,R1,R11",
          "narrow rdata", 64'(n_rsp_rdata), 64'(ref_word(seg_of(a, plen), a + 32'(4 * k))));
      chk(n_rsp_reop === (k == n - 1), "R2,R5", "narrow reop", 64'(n_rsp_reop), 64'(k == n - 1));
      @(negedge clk);
    end
    #1 chk(n_rsp_valid === 1'b0, "R2", "narrow flit count", 64'(n_rsp_valid), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; want = 1'b0; rdy_mode = 0; prev_stall = 1'b0;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_plen = '0; cmd_op = '0; cmd_eop = 1'b0; rsp_ready = 1'b0;
    w_addr = '0; w_plen = '0; w_op = '0; w_eop = 1'b0; w_note = "";
    n_cmd_valid = 1'b0; n_cmd_addr = '0; n_cmd_plen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(cmd_ready === 1'b1, "R10", "reset cmd_ready", 64'(cmd_ready), 64'h1);
    chk(n_rsp_valid === 1'b0, "R10", "reset narrow valid", 64'(n_rsp_valid), 64'h0);
    rst_n = 1'b1;

    issue(32'h1000, 8'd16, 2'b01, 1'b1, "");
    issue(32'h1004, 8'd12, 2'b01, 1'b1, "");
    issue(32'h1030, 8'd16, 2'b01, 1'b1, "");
    issue(32'h1034, 8'd16, 2'b01, 1'b1, "");
    rdy_mode = 2;
    issue(32'h4000, 8'd40, 2'b01, 1'b1, "");
    issue(32'h4024, 8'd4,  2'b01, 1'b1, "");
    issue(32'h2000, 8'd8,  2'b01, 1'b1, "");
    issue(32'h0FFC, 8'd8,  2'b01, 1'b1, "");
    rdy_mode = 0;
    issue(32'h1000, 8'd8,  2'b10, 1'b1, "");
    issue(32'h1000, 8'd8,  2'b01, 1'b1, ",R8");
    issue(32'h1000, 8'd8,  2'b00, 1'b1, "");
    issue(32'h1000, 8'd8,  2'b11, 1'b1, "");
    issue(32'h1000, 8'd8,  2'b01, 1'b0, "");
    issue(32'h1000, 8'd0,  2'b01, 1'b1, "");
    issue(32'h1000, 8'd6,  2'b01, 1'b1, "");
    issue(32'h1002, 8'd8,  2'b01, 1'b1, "");

    for (int i = 0; i < 60; i++) begin
      int s = $urandom % 2;
      logic [31:0] a = BASES[s] + 32'(4 * ($urandom % (SIZES[s] / 4 + 3)));
      logic [7:0] pl = 8'(4 * (1 + $urandom % 8));
      rdy_mode = 1 + $urandom % 2;
      issue(a, pl, 2'b01, 1'b1, "");
    end

    // Reset in the middle of a stalled burst (R10)
    rdy_mode = 3;
    want = 1'b1; w_addr = 32'h1000; w_plen = 8'd32; w_op = 2'b01; w_eop = 1'b1; w_note = "";
    do step(); while (!last_acc);
    want = 1'b0;
    step(); step();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R10", "mid-burst reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(cmd_ready === 1'b1, "R10", "mid-burst reset cmd_ready", 64'(cmd_ready), 64'h1);
    q_data.delete(); q_err.delete(); q_eop.delete(); q_tag.delete();
    prev_stall = 1'b0;
    rst_n = 1'b1;
    rdy_mode = 0;
    issue(32'h4008, 8'd12, 2'b01, 1'b1, ",R10");

    narrow_read(32'h1008, 8'd12);
    narrow_read(32'h4024, 8'd4);
    narrow_read(32'h4000, 8'd16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule